// File: doc/BRIEF.md
# Popcount Byte-Flip Line Encoder and Decoder

This block turns a 16-bit scrambled payload word and its two-bit word-type marker into a 20-bit line word. It suits a short-haul serial link driven through coupling transformers. Each 8-bit half of the payload has its set bits counted. A half that carries too few ones is sent inverted, and a per-half flag records the inversion. The parity of the payload is folded into one marker bit. The four added bits are interleaved with the halves, so every line word stays dense in ones and zero runs stay short. This gives the same 25% overhead as a 4-to-5 bit code.

The transmit side also keeps a saturating running disparity count, which is ones minus zeros summed over every word sent. When that count leaves a symmetric window, the block asks for a balancing correction word. The receive side is a separate path. It undoes the inversions and strips the parity from the markers. It flags a word whose recovered marker is not a legal one-hot code. Both paths take one clock from input to registered output.

Top module: `bytefold_codec`

## Requirements
- R1: One clock after `tx_valid_i` is high, `line_o` carries the encoded word and `line_valid_o` is high. The layout is: bit 19 high-half flip flag, bit 18 marker bit 1, bits 17:10 high half, bit 9 low-half flip flag, bit 8 marker bit 0 with parity, bits 7:0 low half. `line_valid_o` follows `tx_valid_i` by one clock, and `line_o` holds its value while no word is accepted.
- R2: A payload half with fewer than 4 set bits is sent inverted and its flip flag is 1. A half with 4 or more set bits is sent unchanged and its flag is 0.
- R3: The parity, which is the XOR of all 16 payload bits before any inversion, is XORed into marker bit 0 (line bit 8). Marker bit 1 (line bit 18) is sent unchanged.
- R4: In a back-to-back stream of valid line words serialized MSB first, no more than 10 consecutive zero bits appear, both within a word and across word boundaries.
- R5: `drift_o` is a signed 8-bit count. It is 0 after reset. Each accepted word adds (ones minus zeros) of its 20-bit line word, which is 2*ones-20. The count is unchanged in cycles with no accepted word.
- R6: `drift_o` saturates at +127 and at -128 instead of wrapping.
- R7: `corr_req_o` is high exactly when `drift_o` is greater than +48 or less than -48.
- R8: One clock after `rx_valid_i` is high, `rx_data_o` holds the two halves of `rx_line_i`, each re-inverted when its flip flag is set. `rx_mark_o` holds {bit 18, bit 8 XOR parity of the restored data}, and `rx_valid_o` is high. The receive outputs hold their values otherwise. An error-free encoded word decodes back to its original payload and marker.
- R9: Legal marker codes are one-hot: 2'b01 marks a data word and 2'b10 marks a control word. `rx_perr_o` is set with the decoded word when the recovered marker is not one-hot, so any single bit error in a payload half is reported.
- R10: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Accept a payload word this cycle |
| tx_data_i | input | 16 | Scrambled payload word |
| tx_mark_i | input | 2 | Word-type marker (01 data, 10 control) |
| line_valid_o | output | 1 | `line_o` was updated this cycle |
| line_o | output | 20 | Encoded line word |
| drift_o | output | 8 | Signed running disparity |
| corr_req_o | output | 1 | Disparity outside the window; correction word wanted |
| rx_valid_i | input | 1 | Decode `rx_line_i` this cycle |
| rx_line_i | input | 20 | Received line word |
| rx_valid_o | output | 1 | Receive outputs were updated this cycle |
| rx_data_o | output | 16 | Restored payload |
| rx_mark_o | output | 2 | Restored marker |
| rx_perr_o | output | 1 | Recovered marker is not one-hot |

## Verification
Two situations are hard to reach from the ports. The first is negative saturation of the disparity count: every line word holds at least nine ones, so the count falls by at most 2 per word. The stimulus therefore streams about seventy minimum-weight words back to back, and then climbs to positive saturation with all-zero payloads. The second is the worst-case zero run. It only arises when a half that ends in four zeros meets two zero flag/marker bits and a half that starts with four zeros. Directed word pairs place this pattern both inside one word and across a word boundary, while the bench tracks the serialized run. A long random phase with gaps, mixed markers and injected single-bit line errors then exercises both paths against the behavioural model on every clock.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int NHALF = 2;  // payload halves, one marker bit per half
  typedef enum logic [NHALF-1:0] {
    MK_DATA = 2'b01,
    MK_CTRL = 2'b10
  } mark_e;
endpackage

// File: rtl/bfc_seg_enc.sv
module bfc_seg_enc #(
  parameter int W        = 8,
  parameter int FLIP_MIN = 4
) (
  input  logic [W-1:0] half_i,
  output logic         flip_o,
  output logic [W-1:0] coded_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(half_i[i]);
  end

  assign flip_o  = int'(cnt) < FLIP_MIN;
  assign coded_o = flip_o ? ~half_i : half_i;
endmodule

// File: rtl/bfc_seg_dec.sv
module bfc_seg_dec #(
  parameter int W = 8
) (
  input  logic [W+1:0] seg_i,  // {flip, marker, half}
  output logic [W-1:0] half_o,
  output logic         mark_o
);
  assign half_o = seg_i[W-1:0] ^ {W{seg_i[W+1]}};
  assign mark_o = seg_i[W];
endmodule

// File: rtl/bfc_drift.sv
module bfc_drift #(
  parameter int LINE_W  = 20,
  parameter int DRIFT_W = 8,
  parameter int LIMIT   = 48
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [LINE_W-1:0]         word_i,
  output logic signed [DRIFT_W-1:0] drift_o,
  output logic                      corr_o
);
  localparam int DMAX = 2 ** (DRIFT_W - 1) - 1;
  localparam int DMIN = -DMAX - 1;

  logic signed [DRIFT_W-1:0] drift_q;
  int ones;
  int acc;

  always_comb begin
    ones = 0;
    for (int i = 0; i < LINE_W; i++) ones = ones + int'(word_i[i]);
    acc = int'(drift_q) + 2 * ones - LINE_W;
    if (acc > DMAX)      acc = DMAX;
    else if (acc < DMIN) acc = DMIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   drift_q <= '0;
    else if (en_i) drift_q <= DRIFT_W'(acc);
  end

  assign drift_o = drift_q;
  assign corr_o  = (int'(drift_q) > LIMIT) || (int'(drift_q) < -LIMIT);
endmodule

// File: rtl/bytefold_codec.sv
module bytefold_codec
  import bfc_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int FLIP_MIN    = 4,
  parameter int DRIFT_W     = 8,
  parameter int DRIFT_LIMIT = 48
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tx_valid_i,
  input  logic [NHALF*HALF_W-1:0]          tx_data_i,
  input  logic [NHALF-1:0]                 tx_mark_i,
  output logic                             line_valid_o,
  output logic [NHALF*(HALF_W+2)-1:0]      line_o,
  output logic signed [DRIFT_W-1:0]        drift_o,
  output logic                             corr_req_o,
  input  logic                             rx_valid_i,
  input  logic [NHALF*(HALF_W+2)-1:0]      rx_line_i,
  output logic                             rx_valid_o,
  output logic [NHALF*HALF_W-1:0]          rx_data_o,
  output logic [NHALF-1:0]                 rx_mark_o,
  output logic                             rx_perr_o
);
  localparam int DATA_W = NHALF * HALF_W;
  localparam int SEG_W  = HALF_W + 2;
  localparam int LINE_W = NHALF * SEG_W;

  // transmit: parity lands on marker bit 0 (segment 0)
  logic              tx_par;
  logic [NHALF-1:0]  mark_eff;
  logic [LINE_W-1:0] line_d;

  assign tx_par   = ^tx_data_i;
  assign mark_eff = tx_mark_i ^ {{(NHALF-1){1'b0}}, tx_par};

  for (genvar g = 0; g < NHALF; g++) begin : g_enc
    logic              flip;
    logic [HALF_W-1:0] coded;
    bfc_seg_enc #(.W(HALF_W), .FLIP_MIN(FLIP_MIN)) u_enc (
      .half_i (tx_data_i[g*HALF_W +: HALF_W]),
      .flip_o (flip),
      .coded_o(coded)
    );
    assign line_d[g*SEG_W +: SEG_W] = {flip, mark_eff[g], coded};
  end

  bfc_drift #(.LINE_W(LINE_W), .DRIFT_W(DRIFT_W), .LIMIT(DRIFT_LIMIT)) u_drift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_valid_i),
    .word_i (line_d),
    .drift_o(drift_o),
    .corr_o (corr_req_o)
  );

  // receive
  logic [DATA_W-1:0] rx_data_d;
  logic [NHALF-1:0]  rx_raw_mark;
  logic [NHALF-1:0]  rx_mark_d;
  logic              rx_par;
  int                hot;

  for (genvar g = 0; g < NHALF; g++) begin : g_dec
    bfc_seg_dec #(.W(HALF_W)) u_dec (
      .seg_i (rx_line_i[g*SEG_W +: SEG_W]),
      .half_o(rx_data_d[g*HALF_W +: HALF_W]),
      .mark_o(rx_raw_mark[g])
    );
  end

  assign rx_par    = ^rx_data_d;
  assign rx_mark_d = rx_raw_mark ^ {{(NHALF-1){1'b0}}, rx_par};

  always_comb begin
    hot = 0;
    for (int i = 0; i < NHALF; i++) hot = hot + int'(rx_mark_d[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_valid_o <= 1'b0;
      line_o       <= '0;
      rx_valid_o   <= 1'b0;
      rx_data_o    <= '0;
      rx_mark_o    <= '0;
      rx_perr_o    <= 1'b0;
    end else begin
      line_valid_o <= tx_valid_i;
      if (tx_valid_i) line_o <= line_d;
      rx_valid_o <= rx_valid_i;
      if (rx_valid_i) begin
        rx_data_o <= rx_data_d;
        rx_mark_o <= rx_mark_d;
        rx_perr_o <= (hot != 1);
      end
    end
  end
endmodule

// File: rtl/bfc_codec_chk.sv
module bfc_codec_chk #(
  parameter int HALF_W   = 8,
  parameter int FLIP_MIN = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [2*HALF_W-1:0]       tx_data_i,
  input logic [1:0]                tx_mark_i,
  input logic                      line_valid_o,
  input logic [2*(HALF_W+2)-1:0]   line_o,
  input logic signed [7:0]         drift_o,
  input logic                      rx_valid_o,
  input logic [1:0]                rx_mark_o,
  input logic                      rx_perr_o
);
  localparam int SEG_W = HALF_W + 2;

  for (genvar g = 0; g < 2; g++) begin : g_half
    // R2
    flip_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_valid_o |-> line_o[g*SEG_W + HALF_W + 1] ==
        ($countones($past(tx_data_i[g*HALF_W +: HALF_W])) < FLIP_MIN));
    // R4
    half_density_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_valid_o |-> $countones(line_o[g*SEG_W +: HALF_W]) >= FLIP_MIN);
  end

  // R3
  marker_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> (line_o[SEG_W + HALF_W] == $past(tx_mark_i[1])) &&
      (line_o[HALF_W] == ($past(tx_mark_i[0]) ^ (^$past(tx_data_i)))));

  // R5
  drift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_valid_o |-> $stable(drift_o));

  // R9
  rx_mark_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_perr_o || $onehot(rx_mark_o)));
endmodule

bind bytefold_codec bfc_codec_chk #(.HALF_W(HALF_W), .FLIP_MIN(FLIP_MIN)) u_chk (.*);

// File: tb/tb_bytefold_codec.sv
`timescale 1ns/1ps
module tb_bytefold_codec;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tx_valid_i;
  logic [15:0] tx_data_i;
  logic [1:0]  tx_mark_i;
  logic        line_valid_o;
  logic [19:0] line_o;
  logic signed [7:0] drift_o;
  logic        corr_req_o;
  logic        rx_valid_i;
  logic [19:0] rx_line_i;
  logic        rx_valid_o;
  logic [15:0] rx_data_o;
  logic [1:0]  rx_mark_o;
  logic        rx_perr_o;

  always #2.5 clk = ~clk;

  bytefold_codec dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_mark_i(tx_mark_i),
    .line_valid_o(line_valid_o), .line_o(line_o),
    .drift_o(drift_o), .corr_req_o(corr_req_o),
    .rx_valid_i(rx_valid_i), .rx_line_i(rx_line_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .rx_mark_o(rx_mark_o), .rx_perr_o(rx_perr_o)
  );

  int vectors = 0;
  int miss = 0;

  // reference state
  logic [19:0] e_line = '0;
  int          e_drift = 0;
  logic [15:0] e_rdata = '0;
  logic [1:0]  e_rmark = '0;
  logic        e_perr = 1'b0;
  int          zrun = 0;
  int          zmax = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [19:0] m_enc(input logic [15:0] d, input logic [1:0] mk);
    logic [7:0] hi;
    logic [7:0] lo;
    logic fh;
    logic fl;
    hi = d[15:8];
    lo = d[7:0];
    fh = $countones(hi) < 4;
    fl = $countones(lo) < 4;
    if (fh) hi = ~hi;
    if (fl) lo = ~lo;
    return {fh, mk[1], hi, fl, mk[0] ^ (^d), lo};
  endfunction

  task automatic step(input logic v, input logic [15:0] d, input logic [1:0] mk,
                      input logic rv, input logic [19:0] rl);
    logic [15:0] rd;
    tx_valid_i = v; tx_data_i = d; tx_mark_i = mk;
    rx_valid_i = rv; rx_line_i = rl;
    @(negedge clk);
    if (v) begin
      e_line  = m_enc(d, mk);
      e_drift = e_drift + 2 * $countones(e_line) - 20;
      if (e_drift > 127) e_drift = 127;
      if (e_drift < -128) e_drift = -128;
    end
    if (rv) begin
      rd = {rl[17:10] ^ {8{rl[19]}}, rl[7:0] ^ {8{rl[9]}}};
      e_rdata = rd;
      e_rmark = {rl[18], rl[8] ^ (^rd)};
      e_perr  = !(e_rmark == 2'b01 || e_rmark == 2'b10);
    end
    chk(line_valid_o == v, "R1 line_valid", int'(line_valid_o), int'(v));
    chk(line_o == e_line, "R1 line word", int'(line_o), int'(e_line));
    chk(int'(drift_o) == e_drift, "R5 drift", int'(drift_o), e_drift);
    chk(corr_req_o == (e_drift > 48 || e_drift < -48), "R7 corr_req",
        int'(corr_req_o), int'(e_drift > 48 || e_drift < -48));
    chk(rx_valid_o == rv, "R8 rx_valid", int'(rx_valid_o), int'(rv));
    chk(rx_data_o == e_rdata, "R8 rx_data", int'(rx_data_o), int'(e_rdata));
    chk(rx_mark_o == e_rmark, "R8 rx_mark", int'(rx_mark_o), int'(e_rmark));
    chk(rx_perr_o == e_perr, "R9 rx_perr", int'(rx_perr_o), int'(e_perr));
    if (line_valid_o) begin
      for (int b = 19; b >= 0; b--) begin
        if (line_o[b] == 1'b0) zrun++;
        else zrun = 0;
        if (zrun > zmax) zmax = zrun;
      end
      chk(zmax <= 10, "R4 zero run", zmax, 10);
    end else begin
      zrun = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [1:0]  mk;
    logic [19:0] rl;
    rst_ni = 1'b0;
    tx_valid_i = 0; tx_data_i = '0; tx_mark_i = '0;
    rx_valid_i = 0; rx_line_i = '0;
    repeat (3) @(negedge clk);
    // R10
    chk(line_valid_o == 0 && line_o == 0 && rx_valid_o == 0, "R10 reset tx/rx valid",
        int'(line_o), 0);
    chk(drift_o == 0 && corr_req_o == 0, "R10 reset drift", int'(drift_o), 0);
    chk(rx_data_o == 0 && rx_mark_o == 0 && rx_perr_o == 0, "R10 reset rx data",
        int'(rx_data_o), 0);
    rst_ni = 1'b1;

    // R2: 3 ones and 1 one -> both halves inverted
    step(1, 16'h0708, bfc_pkg::MK_DATA, 0, '0);
    chk(line_o[19] && line_o[9] && line_o[17:10] == 8'hF8 && line_o[7:0] == 8'hF7,
        "R2 sparse halves inverted", int'(line_o), 20'hBE3F7);
    // R2: exactly 4 ones per half -> unchanged
    step(1, 16'h0F0F, bfc_pkg::MK_CTRL, 0, '0);
    chk(!line_o[19] && !line_o[9] && line_o[17:10] == 8'h0F, "R2 threshold kept",
        int'(line_o), 20'h43C0F);
    // R3: odd payload flips marker bit 0
    step(1, 16'h1F0F, bfc_pkg::MK_DATA, 0, '0);
    chk(line_o[8] == 1'b0 && line_o[18] == 1'b0, "R3 parity in marker",
        int'(line_o[18:8]), 0);
    // R4: worst run inside a word, then across a word boundary
    step(0, '0, '0, 0, '0);
    zmax = 0;
    step(1, 16'hF00F, bfc_pkg::MK_CTRL, 0, '0);
    chk(zmax == 10, "R4 in-word worst run", zmax, 10);
    step(0, '0, '0, 0, '0);
    zmax = 0;
    step(1, 16'hFFF0, bfc_pkg::MK_CTRL, 0, '0);
    step(1, 16'h0F0F, bfc_pkg::MK_DATA, 0, '0);
    chk(zmax == 10, "R4 cross-word worst run", zmax, 10);
    // R1: hold with no valid
    step(0, 16'h1234, bfc_pkg::MK_DATA, 0, '0);
    chk(line_o == m_enc(16'h0F0F, bfc_pkg::MK_DATA), "R1 line held", int'(line_o),
        int'(m_enc(16'h0F0F, bfc_pkg::MK_DATA)));

    // R8: clean round trip; R9: single bit error
    step(0, '0, '0, 1, m_enc(16'hA5C3, bfc_pkg::MK_CTRL));
    chk(rx_data_o == 16'hA5C3 && rx_mark_o == 2'b10 && !rx_perr_o, "R8 round trip",
        int'(rx_data_o), 16'hA5C3);
    step(0, '0, '0, 1, m_enc(16'h1234, bfc_pkg::MK_DATA) ^ 20'h00400);
    chk(rx_perr_o == 1'b1, "R9 single error flagged", int'(rx_perr_o), 1);

    // R6: negative saturation, then positive
    for (int i = 0; i < 70; i++) step(1, 16'h0F0F, bfc_pkg::MK_CTRL, 0, '0);
    chk(int'(drift_o) == -128, "R6 low saturation", int'(drift_o), -128);
    chk(corr_req_o == 1'b1, "R7 low window", int'(corr_req_o), 1);
    for (int i = 0; i < 20; i++) step(1, 16'h0000, bfc_pkg::MK_DATA, 0, '0);
    chk(int'(drift_o) == 127, "R6 high saturation", int'(drift_o), 127);

    // mixed random traffic on both paths
    zmax = 0;
    for (int i = 0; i < 3000; i++) begin
      d  = 16'($urandom);
      mk = $urandom_range(0, 1) ? bfc_pkg::MK_DATA : bfc_pkg::MK_CTRL;
      rl = m_enc(16'($urandom), $urandom_range(0, 1) ? 2'b01 : 2'b10);
      if ($urandom_range(0, 3) == 0) rl = rl ^ (20'h1 << $urandom_range(0, 19));
      step(($urandom_range(0, 7) != 0), d, mk, ($urandom_range(0, 3) != 0), rl);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule